// File: doc/BRIEF.md
# Serial Link Start-Up Sequencer

This block brings a current-mode serial display link from a dark, zero-current state to data streaming. The link has one clock lane and up to three data lanes. The sequencer runs on the pixel clock. It watches an active-low power-down input, a pixel-clock-present flag and a bias-ready flag. When both enables are high, it waits for the bias circuits. It then drives the clock lane through a timed low/high/low current handshake, which the far end uses to wake up and calibrate its receivers. After that it waits out a PLL hold-off interval and only then switches the lanes to streaming.

For each lane, the outputs are symbolic drive states rather than analog controls. Two further outputs report the clock-lane current in units and the present link phase. A streaming-enable flag tells the serializer datapath when it may send pixels. Dropping either enable at any time returns the link to the off phase on the next edge. Every step counter is cleared at that point, so the next start-up repeats the full sequence.

Top module: `link_startup_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, every lane state is off, `link_phase` is off, `stream_en` is 0 and `clk_lane_current` is 0.
- R2: Lane state codes are 0 = off, 1 = logic low, 2 = logic high, 3 = active. `link_phase` codes are 0 = off, 1 = link-up, 2 = active. Data lane n occupies bits [2n+1:2n] of `data_lane_state`.
- R3: The link leaves off only on an edge at which `pwr_dn_n` and `pclk_present` are both 1. It then enters the bias wait: phase link-up, all lanes off. While either input is 0, it stays off.
- R4: In the bias wait, the edge that samples `bias_ready` high starts the first low step. With `bias_ready` already high on entry, the bias wait lasts exactly 1 cycle. If `bias_ready` stays low for `BIAS_TIMEOUT` cycles, the link spends one cycle off and then re-enters the bias wait.
- R5: First pulse step: the clock lane is logic low for exactly `LOW1_CYCLES` cycles (default 200), with the data lanes off.
- R6: Second pulse step: the clock lane is logic high for exactly `HIGH_CYCLES` cycles (default 20), with the data lanes off.
- R7: Third pulse step: the clock lane is logic low for exactly `LOW2_CYCLES` cycles (default 8), with the data lanes off.
- R8: PLL hold-off: for exactly `HOLD_CYCLES` cycles (default 600), the clock lane and all data lanes are logic low, the phase stays link-up and `stream_en` stays 0.
- R9: After the hold-off, the clock lane and all data lanes are active, the phase is active and `stream_en` is 1. This state lasts until an abort.
- R10: If `pwr_dn_n` or `pclk_present` is 0 at an edge, in any phase, the next state is off. The following start-up again runs every step for its full length.
- R11: `clk_lane_current` follows the clock lane: off 0, logic low 5, logic high 1, active 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn_n | input | 1 | Power-down, active low |
| pclk_present | input | 1 | Pixel clock is running |
| bias_ready | input | 1 | Bias block has powered up |
| clk_lane_state | output | 2 | Clock lane drive state |
| data_lane_state | output | 2*DATA_LANES | Data lane drive states, lane n at [2n+1:2n] |
| clk_lane_current | output | 3 | Clock lane current in units |
| link_phase | output | 2 | Link phase: off, link-up, active |
| stream_en | output | 1 | Streaming allowed |

## Verification
The bench builds the block with its default parameters: three data lanes, step lengths of 200, 20, 8 and 600 cycles, and a bias timeout of 1000. With these values, every step's exact length is measured at the lane outputs against the real handshake timing. A complete start-up fits several times into the run, which allows the bench to abort the link in the middle of a pulse and in streaming and then check a full-length restart. The 1000-cycle timeout is short enough to observe its retry directly.

// File: rtl/lsq_pkg.sv
// Shared encodings for the link start-up sequencer.
// Assumes: lane codes and phase codes are visible at the top ports.
package lsq_pkg;
    typedef enum logic [1:0] {
        LANE_OFF  = 2'd0,
        LANE_LOW  = 2'd1,
        LANE_HIGH = 2'd2,
        LANE_ACT  = 2'd3
    } lane_drive_e;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_LINKUP = 2'd1,
        PH_ACTIVE = 2'd2
    } link_phase_e;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_BIAS      = 3'd1,
        ST_PULSE_LO  = 3'd2,
        ST_PULSE_HI  = 3'd3,
        ST_SETTLE_LO = 3'd4,
        ST_HOLDOFF   = 3'd5,
        ST_STREAM    = 3'd6
    } seq_step_e;

    localparam logic [2:0] CUR_OFF  = 3'd0;
    localparam logic [2:0] CUR_LOW  = 3'd5;
    localparam logic [2:0] CUR_HIGH = 3'd1;
    localparam logic [2:0] CUR_ACT  = 3'd3;
endpackage

// File: rtl/lsq_step_timer.sv
// Step duration counter. Restarts from zero on request and counts up
// until it reaches limit-1, where it parks and flags expiry.
// Assumes: limit is at least 1 and stable while a step runs.
module lsq_step_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          expired
);
    // Expiry compare against the step's last cycle.
    assign expired = (count == limit - CW'(1));

    // Count cycles spent in the current step.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (restart)  count <= '0;
        else if (!expired) count <= count + CW'(1);
    end

    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
endmodule

// File: rtl/lsq_seq_fsm.sv
// Start-up step controller. Chooses the next step from the enables,
// the bias flag and the timer, and gives the timer its limit.
// Assumes: the timer's expired output refers to the current step.
module lsq_seq_fsm
    import lsq_pkg::*;
#(
    parameter int CW           = 10,
    parameter int BIAS_TIMEOUT = 1000,
    parameter int LOW1_CYCLES  = 200,
    parameter int HIGH_CYCLES  = 20,
    parameter int LOW2_CYCLES  = 8,
    parameter int HOLD_CYCLES  = 600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_en,
    input  logic          bias_ready,
    input  logic          expired,
    output seq_step_e     step,
    output logic [CW-1:0] step_limit,
    output logic          restart
);
    seq_step_e nxt;

    // Next-step selection; a lost enable wins over everything else.
    always_comb begin
        nxt = step;
        if (!link_en) begin
            nxt = ST_OFF;
        end else begin
            case (step)
                ST_OFF:       nxt = ST_BIAS;
                ST_BIAS:      if (bias_ready) nxt = ST_PULSE_LO;
                              else if (expired) nxt = ST_OFF;
                ST_PULSE_LO:  if (expired) nxt = ST_PULSE_HI;
                ST_PULSE_HI:  if (expired) nxt = ST_SETTLE_LO;
                ST_SETTLE_LO: if (expired) nxt = ST_HOLDOFF;
                ST_HOLDOFF:   if (expired) nxt = ST_STREAM;
                ST_STREAM:    nxt = ST_STREAM;
                default:      nxt = ST_OFF;
            endcase
        end
    end

    // Timer restarts whenever the step changes.
    assign restart = (nxt != step);

    // Duration of the current step.
    always_comb begin
        case (step)
            ST_BIAS:      step_limit = CW'(BIAS_TIMEOUT);
            ST_PULSE_LO:  step_limit = CW'(LOW1_CYCLES);
            ST_PULSE_HI:  step_limit = CW'(HIGH_CYCLES);
            ST_SETTLE_LO: step_limit = CW'(LOW2_CYCLES);
            ST_HOLDOFF:   step_limit = CW'(HOLD_CYCLES);
            default:      step_limit = CW'(1);
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_OFF;
        else        step <= nxt;
    end

    a_r3_off_exit_to_bias: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_OFF) |=> (step == ST_OFF || step == ST_BIAS));
    a_r10_abort_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (step == ST_OFF));
endmodule

// File: rtl/lsq_lane_encoder.sv
// Maps the start-up step to lane drive states, clock-lane current,
// link phase and the streaming flag. Purely combinational.
// Assumes: all data lanes share one drive state.
module lsq_lane_encoder
    import lsq_pkg::*;
#(
    parameter int DATA_LANES = 3
) (
    input  seq_step_e                  step,
    output logic [1:0]                 clk_state,
    output logic [2*DATA_LANES-1:0]    data_state,
    output logic [2:0]                 clk_current,
    output logic [1:0]                 phase,
    output logic                       stream
);
    lane_drive_e ck, dt;

    // Lane drive per step.
    always_comb begin
        ck = LANE_OFF;
        dt = LANE_OFF;
        case (step)
            ST_PULSE_LO:  ck = LANE_LOW;
            ST_PULSE_HI:  ck = LANE_HIGH;
            ST_SETTLE_LO: ck = LANE_LOW;
            ST_HOLDOFF:   begin ck = LANE_LOW; dt = LANE_LOW; end
            ST_STREAM:    begin ck = LANE_ACT; dt = LANE_ACT; end
            default:      ;
        endcase
    end

    // Clock-lane current in units.
    always_comb begin
        case (ck)
            LANE_LOW:  clk_current = CUR_LOW;
            LANE_HIGH: clk_current = CUR_HIGH;
            LANE_ACT:  clk_current = CUR_ACT;
            default:   clk_current = CUR_OFF;
        endcase
    end

    // Phase and streaming flag.
    always_comb begin
        if (step == ST_OFF)         phase = PH_OFF;
        else if (step == ST_STREAM) phase = PH_ACTIVE;
        else                        phase = PH_LINKUP;
    end

    assign stream    = (step == ST_STREAM);
    assign clk_state = ck;

    for (genvar g = 0; g < DATA_LANES; g++) begin : g_lane
        assign data_state[2*g +: 2] = dt;
    end
endmodule

// File: rtl/link_startup_seq.sv
// Start-up sequencer for a current-mode serial display link.
// Brings the link from off through a timed low/high/low clock-lane
// handshake and a PLL hold-off into streaming.
// Assumes: all inputs are synchronous to clk; step lengths >= 1.
module link_startup_seq
    import lsq_pkg::*;
#(
    parameter int DATA_LANES   = 3,
    parameter int BIAS_TIMEOUT = 1000,
    parameter int LOW1_CYCLES  = 200,
    parameter int HIGH_CYCLES  = 20,
    parameter int LOW2_CYCLES  = 8,
    parameter int HOLD_CYCLES  = 600
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwr_dn_n,
    input  logic                    pclk_present,
    input  logic                    bias_ready,
    output logic [1:0]              clk_lane_state,
    output logic [2*DATA_LANES-1:0] data_lane_state,
    output logic [2:0]              clk_lane_current,
    output logic [1:0]              link_phase,
    output logic                    stream_en
);
    localparam int M1   = (LOW1_CYCLES > HIGH_CYCLES) ? LOW1_CYCLES : HIGH_CYCLES;
    localparam int M2   = (LOW2_CYCLES > HOLD_CYCLES) ? LOW2_CYCLES : HOLD_CYCLES;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int MAXC = (M3 > BIAS_TIMEOUT) ? M3 : BIAS_TIMEOUT;
    localparam int CW   = $clog2(MAXC + 1);

    logic          link_en;
    logic          expired;
    logic          restart;
    logic [CW-1:0] step_limit;
    logic [CW-1:0] count;
    seq_step_e     step;

    // Link may run only with power-down released and the clock present.
    assign link_en = pwr_dn_n & pclk_present;

    lsq_seq_fsm #(
        .CW(CW), .BIAS_TIMEOUT(BIAS_TIMEOUT), .LOW1_CYCLES(LOW1_CYCLES),
        .HIGH_CYCLES(HIGH_CYCLES), .LOW2_CYCLES(LOW2_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .bias_ready(bias_ready),
        .expired(expired), .step(step), .step_limit(step_limit), .restart(restart)
    );

    lsq_step_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .limit(step_limit),
        .count(count), .expired(expired)
    );

    lsq_lane_encoder #(.DATA_LANES(DATA_LANES)) u_enc (
        .step(step), .clk_state(clk_lane_state), .data_state(data_lane_state),
        .clk_current(clk_lane_current), .phase(link_phase), .stream(stream_en)
    );

    a_r5_low1_length: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_PULSE_HI && $past(step) == ST_PULSE_LO) |-> ($past(count) == CW'(LOW1_CYCLES - 1)));
    a_r6_high_length: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_SETTLE_LO && $past(step) == ST_PULSE_HI) |-> ($past(count) == CW'(HIGH_CYCLES - 1)));
    a_r7_low2_length: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_HOLDOFF && $past(step) == ST_SETTLE_LO) |-> ($past(count) == CW'(LOW2_CYCLES - 1)));
    a_r8_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_STREAM && $past(step) == ST_HOLDOFF) |-> ($past(count) == CW'(HOLD_CYCLES - 1)));
    a_r9_stream_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_en) |-> ($past(step) == ST_HOLDOFF));
    a_r4_bias_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_OFF && $past(step) == ST_BIAS && $past(link_en)) |-> ($past(count) == CW'(BIAS_TIMEOUT - 1)));
endmodule

// File: tb/tb_link_startup_seq.sv
// Directed bench for link_startup_seq: one task per scenario.
module tb_link_startup_seq;
    localparam int DL = 3;
    localparam int SW = 2 + 2*DL + 2 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn_n = 1'b0;
    logic pclk_present = 1'b0;
    logic bias_ready = 1'b0;
    logic [1:0]      clk_lane_state;
    logic [2*DL-1:0] data_lane_state;
    logic [2:0]      clk_lane_current;
    logic [1:0]      link_phase;
    logic            stream_en;

    int n_chk = 0;
    int n_fail = 0;

    link_startup_seq #(.DATA_LANES(DL)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .pclk_present(pclk_present),
        .bias_ready(bias_ready), .clk_lane_state(clk_lane_state),
        .data_lane_state(data_lane_state), .clk_lane_current(clk_lane_current),
        .link_phase(link_phase), .stream_en(stream_en)
    );

    always #10 clk = ~clk;

    function automatic logic [SW-1:0] sig();
        return {clk_lane_state, data_lane_state, link_phase, stream_en};
    endfunction

    function automatic logic [SW-1:0] mk(logic [1:0] c, logic [1:0] d, logic [1:0] p, logic s);
        return {c, {DL{d}}, p, s};
    endfunction

    // Expected signatures (codes per R2).
    localparam logic [SW-1:0] S_OFF  = {2'd0, {DL{2'd0}}, 2'd0, 1'b0};
    localparam logic [SW-1:0] S_BIAS = {2'd0, {DL{2'd0}}, 2'd1, 1'b0};
    localparam logic [SW-1:0] S_LO   = {2'd1, {DL{2'd0}}, 2'd1, 1'b0};
    localparam logic [SW-1:0] S_HI   = {2'd2, {DL{2'd0}}, 2'd1, 1'b0};
    localparam logic [SW-1:0] S_HOLD = {2'd1, {DL{2'd1}}, 2'd1, 1'b0};
    localparam logic [SW-1:0] S_ACT  = {2'd3, {DL{2'd3}}, 2'd2, 1'b1};

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count consecutive negedge samples equal to s.
    task automatic run_len(input logic [SW-1:0] s, output int n);
        n = 0;
        while (sig() == s && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Walk a full start-up from the current sample; bias_ready already high.
    task automatic walk_startup(string tag);
        int n;
        run_len(S_BIAS, n);  chk({tag, " R4 bias wait"}, n, 1);
        chk({tag, " R11 low current"}, int'(clk_lane_current), 5);
        run_len(S_LO, n);    chk({tag, " R5 low1 length"}, n, 200);
        chk({tag, " R11 high current"}, int'(clk_lane_current), 1);
        run_len(S_HI, n);    chk({tag, " R6 high length"}, n, 20);
        run_len(S_LO, n);    chk({tag, " R7 low2 length"}, n, 8);
        run_len(S_HOLD, n);  chk({tag, " R8 hold length"}, n, 600);
        chk({tag, " R9 active state"}, int'(sig()), int'(S_ACT));
        chk({tag, " R11 active current"}, int'(clk_lane_current), 3);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 off during reset", int'(sig()), int'(S_OFF));
        chk("R1 current during reset", int'(clk_lane_current), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 off after reset", int'(sig()), int'(S_OFF));
    endtask

    task automatic t_hold_off();
        pclk_present = 1'b1;
        pwr_dn_n = 1'b0;
        repeat (20) @(negedge clk);
        chk("R3 stays off with power-down low", int'(sig()), int'(S_OFF));
        pwr_dn_n = 1'b1;
        pclk_present = 1'b0;
        repeat (20) @(negedge clk);
        chk("R3 stays off without pixel clock", int'(sig()), int'(S_OFF));
        chk("R11 off current", int'(clk_lane_current), 0);
    endtask

    task automatic t_full_startup();
        bias_ready = 1'b1;
        pclk_present = 1'b1;
        @(negedge clk);
        chk("R3 entered bias wait", int'(sig()), int'(S_BIAS));
        walk_startup("startup");
        repeat (50) @(negedge clk);
        chk("R9 streaming persists", int'(sig()), int'(S_ACT));
    endtask

    task automatic t_abort_active();
        pclk_present = 1'b0;
        @(negedge clk);
        chk("R10 clock loss in active", int'(sig()), int'(S_OFF));
        pclk_present = 1'b1;
        @(negedge clk);
        walk_startup("restart after active abort R10");
    endtask

    task automatic t_abort_pulse();
        int n;
        pwr_dn_n = 1'b0;
        @(negedge clk);
        pwr_dn_n = 1'b1;
        @(negedge clk);
        run_len(S_BIAS, n);
        run_len(S_LO, n);
        repeat (5) @(negedge clk);
        chk("R6 in high step", int'(sig()), int'(S_HI));
        pwr_dn_n = 1'b0;
        @(negedge clk);
        chk("R10 power-down mid pulse", int'(sig()), int'(S_OFF));
        pwr_dn_n = 1'b1;
        @(negedge clk);
        walk_startup("restart after pulse abort R10");
    endtask

    task automatic t_bias_timeout();
        int n;
        pwr_dn_n = 1'b0;
        bias_ready = 1'b0;
        @(negedge clk);
        pwr_dn_n = 1'b1;
        @(negedge clk);
        run_len(S_BIAS, n);  chk("R4 bias timeout length", n, 1000);
        run_len(S_OFF, n);   chk("R4 off for one cycle on timeout", n, 1);
        chk("R4 retry enters bias", int'(sig()), int'(S_BIAS));
        repeat (10) @(negedge clk);
        bias_ready = 1'b1;
        @(negedge clk);
        chk("R4 bias ready starts low step", int'(sig()), int'(S_LO));
        run_len(S_LO, n);    chk("R5 low1 after retry", n, 200);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_hold_off();
        t_full_startup();
        t_abort_active();
        t_abort_pulse();
        t_bias_timeout();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule